// File: doc/BRIEF.md
# Wide Synchronous Counter with Two-Level Lookahead Enables

This block is a 64-bit synchronous up-counter divided into eight 8-bit slices. Inside each slice, every bit decides whether to toggle from one wide AND of the count enable and all lower bits of that slice. No toggle term is chained from one bit to the next. Each slice raises a terminal flag when all of its bits are one. The flag depends only on the slice contents and not on the enable.

The slices form two 32-bit groups. Inside a group, the enable of slice k is a single AND of the group enable and the terminal flags of every lower slice in that group. The lower group takes the external count enable. It produces a group carry, which is the enable ANDed with all four of its flags. That group carry is the enable of the upper group. The two halves are therefore joined in series, and each half is gated in parallel inside. Two controls override counting. A synchronous clear has the highest priority. A synchronous load writes all 64 bits at once, so that high-order patterns can be reached without waiting for them to count up.

Top module: `wide_counter`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, `count` is zero.
- R2: On a rising edge with `clr` high, `count` becomes zero. This takes priority over `ld` and `cnt_en`.
- R3: On a rising edge with `ld` high and `clr` low, `count` takes `ld_data` on all 64 bits. This takes priority over `cnt_en`.
- R4: On a rising edge with `cnt_en` high and `clr` and `ld` low, `count` becomes its previous value plus one, modulo 2^64. The carry crosses slice and group boundaries in that same cycle.
- R5: On a rising edge with `cnt_en`, `clr` and `ld` all low, `count` holds its value.
- R6: `slice_full[k]` is high exactly when `count[8k+7:8k]` is all ones, whatever the state of `cnt_en`.
- R7: `carry_out` is high in the same cycle exactly when `cnt_en` is high and `count` is all ones. This holds regardless of `clr` and `ld`. When counting, the following edge wraps `count` to zero.
- R8: Without a clear or a load, slice k changes value on an edge only if `cnt_en` was high and every bit below that slice was one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous load of `ld_data` |
| cnt_en | input | 1 | Count enable |
| ld_data | input | 64 | Value to load |
| count | output | 64 | Current count |
| slice_full | output | 8 | Per-slice all-ones flags, bit k covers count bits 8k+7:8k |
| carry_out | output | 1 | Enable ANDed with an all-ones count |

## Verification
The bench preloads values just below the 8-bit, 32-bit and 64-bit boundaries, then steps the counter across each one. A wrongly built lookahead term would leave a high slice stuck, or would advance it one step early, and the upper group would fail to move at the 32-bit rollover. The bench parks the counter at all ones with the enable low to confirm that the flags stay up while `carry_out` stays low. Clear is issued together with load to confirm that clear wins. Random traffic mixes loads of values whose low bits are all ones, so that carries reach every level often.

// File: rtl/wide_counter_pkg.sv
package wide_counter_pkg;
  localparam int unsigned WC_SLICE_W    = 8;
  localparam int unsigned WC_PER_GROUP  = 4;
  localparam int unsigned WC_GROUPS     = 2;
endpackage

// File: rtl/wc_slice.sv
module wc_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         full
);
  logic [W-1:0] tog;
  logic [W-1:0] q_nxt;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_tog
      if (i == 0) begin : g_lsb
        assign tog[i] = en;
      end else begin : g_upper
        assign tog[i] = en & (&q[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    if (clr)      q_nxt = '0;
    else if (ld)  q_nxt = ld_val;
    else          q_nxt = q ^ tog;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign full = &q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && !clr) |=> (q == $past(q) + {{(W-1){1'b0}}, 1'b1}));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld && !clr) |=> $stable(q));
endmodule

// File: rtl/wc_group.sv
module wc_group #(
  parameter int unsigned N = 4
) (
  input  logic         en,
  input  logic [N-1:0] flags,
  output logic [N-1:0] slice_en,
  output logic         grp_carry
);
  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_en
      if (k == 0) begin : g_first
        assign slice_en[k] = en;
      end else begin : g_rest
        assign slice_en[k] = en & (&flags[k-1:0]);
      end
    end
  endgenerate

  assign grp_carry = en & (&flags);

  always_comb begin
    if (!en) assert_quiet_R5: assert ((slice_en == '0) && !grp_carry);
  end
endmodule

// File: rtl/wide_counter.sv
module wide_counter
  import wide_counter_pkg::*;
#(
  parameter int unsigned SLICE_W   = WC_SLICE_W,
  parameter int unsigned PER_GROUP = WC_PER_GROUP,
  parameter int unsigned GROUPS    = WC_GROUPS,
  localparam int unsigned SLICES   = PER_GROUP * GROUPS,
  localparam int unsigned WIDTH    = SLICES * SLICE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic             cnt_en,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] count,
  output logic [SLICES-1:0] slice_full,
  output logic             carry_out
);
  logic [GROUPS-1:0] grp_en;
  logic [GROUPS-1:0] grp_cy;
  logic [SLICES-1:0] s_en;

  genvar g, s;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      if (g == 0) begin : g_head
        assign grp_en[g] = cnt_en;
      end else begin : g_chain
        assign grp_en[g] = grp_cy[g-1];
      end

      wc_group #(.N(PER_GROUP)) u_grp (
        .en        (grp_en[g]),
        .flags     (slice_full[g*PER_GROUP +: PER_GROUP]),
        .slice_en  (s_en[g*PER_GROUP +: PER_GROUP]),
        .grp_carry (grp_cy[g])
      );
    end

    for (s = 0; s < SLICES; s++) begin : g_slc
      wc_slice #(.W(SLICE_W)) u_slc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .ld     (ld),
        .ld_val (ld_data[s*SLICE_W +: SLICE_W]),
        .en     (s_en[s]),
        .q      (count[s*SLICE_W +: SLICE_W]),
        .full   (slice_full[s])
      );

      if (s > 0) begin : g_chk
        assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(!clr && !ld) && !$stable(count[s*SLICE_W +: SLICE_W]))
          |-> $past(cnt_en && (&count[s*SLICE_W-1:0])));
      end
    end
  endgenerate

  assign carry_out = grp_cy[GROUPS-1];

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (count == $past(ld_data)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_out && !clr && !ld) |=> (count == '0));

  always_comb begin
    if (!rst_n) assert_reset_R1: assert (count == '0);
  end
endmodule

// File: tb/wide_counter_bench.sv
module wide_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr, ld, cnt_en;
  logic [63:0] ld_data;
  logic [63:0] count;
  logic [7:0]  slice_full;
  logic        carry_out;

  logic [63:0] ref_q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wide_counter u_wide_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ld(ld), .cnt_en(cnt_en),
    .ld_data(ld_data), .count(count), .slice_full(slice_full),
    .carry_out(carry_out)
  );

  function automatic logic [7:0] exp_flags(input logic [63:0] v);
    logic [7:0] f;
    for (int k = 0; k < 8; k++) f[k] = (v[k*8 +: 8] == 8'hFF);
    return f;
  endfunction

  function automatic logic [63:0] exp_next(input logic [63:0] v, input logic c,
                                           input logic l, input logic e,
                                           input logic [63:0] d);
    if (c)      return 64'd0;
    else if (l) return d;
    else if (e) return v + 64'd1;
    else        return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic e,
                      input logic [63:0] d, input string req);
    @(negedge clk);
    clr = c; ld = l; cnt_en = e; ld_data = d;
    #1;
    check("R7 carry_out", {63'd0, carry_out}, {63'd0, (e && (&ref_q))});
    @(posedge clk);
    ref_q = exp_next(ref_q, c, l, e, d);
    #1;
    check(req, count, ref_q);
    check("R6 slice_full", {56'd0, slice_full}, {56'd0, exp_flags(ref_q)});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20240611));
    clr = 0; ld = 0; cnt_en = 0; ld_data = '0;
    rst_n = 1'b0;
    ref_q = '0;
    #9;
    check("R1 reset", count, 64'd0);
    check("R6 reset flags", {56'd0, slice_full}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) step(0, 0, 1, '0, "R4 count from zero");
    step(0, 0, 0, '0, "R5 hold");
    step(0, 0, 0, '0, "R5 hold");
    // 8-bit boundary
    step(0, 1, 1, 64'h0000_0000_0000_00FE, "R3 load beats enable");
    for (int i = 0; i < 3; i++) step(0, 0, 1, '0, "R4 R8 slice boundary");
    // 32-bit boundary into upper group
    step(0, 1, 0, 64'h1234_5678_FFFF_FFFE, "R3 load");
    for (int i = 0; i < 3; i++) step(0, 0, 1, '0, "R4 R8 group boundary");
    // mid-group boundary with gaps
    step(0, 1, 0, 64'h00FF_FFFF_FFFF_FFFF, "R3 load");
    step(0, 0, 0, '0, "R5 hold at flags");
    step(0, 0, 1, '0, "R4 R8 wide carry");
    // 64-bit wrap
    step(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE, "R3 load");
    step(0, 0, 1, '0, "R4 reach all ones");
    step(0, 0, 0, '0, "R5 R6 hold all ones, flags without enable");
    step(0, 0, 0, '0, "R5 R7 no carry without enable");
    step(0, 0, 1, '0, "R7 wrap to zero");
    step(0, 0, 1, '0, "R4 after wrap");
    // clear priority
    step(0, 1, 0, 64'hDEAD_BEEF_0BAD_F00D, "R3 load");
    step(1, 1, 1, 64'h5555_5555_5555_5555, "R2 clear beats load");
    step(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 load ones");
    step(1, 0, 1, '0, "R2 clear beats count");

    for (int i = 0; i < 3000; i++) begin
      int r;
      logic c, l, e;
      r = $urandom_range(0, 99);
      c = (r < 2);
      l = (r >= 2 && r < 8);
      e = ($urandom_range(0, 3) != 0);
      d = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: d[7:0]  = 8'hFD;
        1: d[31:0] = 32'hFFFF_FFFC;
        2: d[55:0] = 56'hFF_FFFF_FFFF_FFFD;
        default: ;
      endcase
      step(c, l, e, d, "R2 R3 R4 R5 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule